// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns bus addresses that fall inside a graphics aperture into physical addresses. The first translation level is a directory of 64 slots kept in flops inside the block. Each slot names a 4 KiB-page table of 1024 second-level words held in system memory. The block reaches those words through a single-outstanding read port. A four-entry fully associative translation cache holds recent results, so repeated pages skip the memory read.

Software sets up the block through a write-only port with four registers. The control register supplies a cache-invalidate strobe. The size register picks one of four aperture lengths. The base register sets where the aperture starts, at 4 MiB granularity. The attach register loads one directory slot per write. Lookups come in over a ready/valid request channel. Each result is a one-cycle response pulse that carries either a physical address with the slot's attribute index, or a fault.

Top module: `apt_xlate`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid and mem_rd are 0. The size code is 0, the base is 0 and every directory slot is absent, so any lookup faults without a memory read.
- R2: A write with reg_addr=3 (attach) loads the slot selected by wdata[5:0] with table page wdata[31:20], attribute index wdata[11:9] and present flag wdata[8]. Bits 19:12 and 7:6 are ignored. A write with the present flag clear makes the slot absent.
- R3: The directory slot is rel = addr[31:22] − base[31:22], where the base is written with reg_addr=2 and only bits 31:22 are kept. The size is written with reg_addr=1 into wdata[7:0]. Code 0 gives 64 slots, 32 gives 32, 48 gives 16, 56 gives 8, and any other code gives none. An address below the base, or with rel at or beyond the slot count, faults with no memory read.
- R4: A lookup that lands on an absent slot faults with no memory read.
- R5: A table walk makes exactly one read at {page, 8'h00, addr[21:12], 2'b00}. mem_rd and mem_addr stay steady until mem_rvalid.
- R6: If bit 0 of the returned word is 1, the response is not a fault: resp_paddr = {mem_rdata[31:12], addr[11:0]} and resp_attr is the slot's attribute index. If bit 0 is 0, the response is a fault. Every fault reports resp_paddr = 0 and resp_attr = 0.
- R7: Only one lookup is outstanding at a time, and req_ready is 1 only when the block is idle. resp_valid lasts one cycle. A lookup that needs no walk responds in the second cycle after it is accepted.
- R8: A translation-cache hit gives the same result as a walk but makes no memory read. The cache has four entries, filled in round-robin order starting from entry 0 after a clear.
- R9: A write with reg_addr=0 clears the cache only when wdata[7] is 1 and the previous control write left bit 7 at 0. Bit 7 resets to 0. A write of 1 over a stored 1, or any write of 0, leaves the cache as it is.
- R10: Every attach write clears the whole cache.
- R11: Faults are never cached. A walk that is under way when a clear happens does not fill the cache.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 size, 2 base, 3 attach |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | 32 | Aperture bus address to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Lookup failed |
| resp_paddr | output | 32 | Translated physical address |
| resp_attr | output | 3 | Attribute index of the directory slot used |
| mem_rd | output | 1 | Second-level table read request |
| mem_addr | output | 32 | Byte address of the table word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table word read back |

## Verification
Most internal errors show up on the memory port before they show up in the data. A cache entry that is stale or evicted early changes the number of reads a lookup makes. A wrong slot or offset changes mem_addr during the walk. A bad range or presence decision either issues a read that should not happen or skips one that should. All of these are visible within the same lookup, so the bench counts reads and records walk addresses for every request. A cache that was wrongly cleared or kept is exposed at the next lookup of the same page. The sweep covers every slot index past the aperture limit under all five size cases, with expected values computed from the address arithmetic.

// File: rtl/apt_pkg.sv
package apt_pkg;

  localparam int unsigned PA_W      = 32;
  localparam int unsigned VPN_W     = 20;
  localparam int unsigned DPAGE_W   = 12;
  localparam int unsigned ATTR_W    = 3;
  localparam int unsigned TOFF_W    = 10;
  localparam int unsigned SLOTSEL_W = 10;

  localparam logic [1:0] RA_CTRL   = 2'd0;
  localparam logic [1:0] RA_SIZE   = 2'd1;
  localparam logic [1:0] RA_BASE   = 2'd2;
  localparam logic [1:0] RA_ATTACH = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WALK  = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_e;

  typedef struct packed {
    logic               present;
    logic [ATTR_W-1:0]  attr;
    logic [DPAGE_W-1:0] page;
  } dir_ent_t;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [ATTR_W-1:0] attr;
  } tlb_ent_t;

  typedef struct packed {
    logic       ok;
    logic [1:0] shift;
  } aper_sz_t;

  // Aperture length code: each step halves the number of live slots.
  function automatic aper_sz_t decode_aper(input logic [7:0] code);
    aper_sz_t r;
    r = '0;
    case (code)
      8'd0:  begin r.ok = 1'b1; r.shift = 2'd0; end
      8'd32: begin r.ok = 1'b1; r.shift = 2'd1; end
      8'd48: begin r.ok = 1'b1; r.shift = 2'd2; end
      8'd56: begin r.ok = 1'b1; r.shift = 2'd3; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/apt_cfg_regs.sv
module apt_cfg_regs
  import apt_pkg::*;
#(
  parameter int unsigned DIR_IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [7:0]           size_code,
  output logic [SLOTSEL_W-1:0] base_hi,
  output logic                 flush_pulse,
  output logic                 attach_we,
  output logic [DIR_IDX_W-1:0] attach_idx,
  output dir_ent_t             attach_ent
);

  logic                 strobe_q, strobe_n;
  logic [7:0]           size_q, size_n;
  logic [SLOTSEL_W-1:0] base_q, base_n;
  logic                 unused_wbits;

  always_comb begin
    strobe_n    = strobe_q;
    size_n      = size_q;
    base_n      = base_q;
    flush_pulse = 1'b0;
    if (reg_wr) begin
      case (reg_addr)
        RA_CTRL: begin
          strobe_n    = reg_wdata[7];
          flush_pulse = reg_wdata[7] & ~strobe_q;
        end
        RA_SIZE: size_n = reg_wdata[7:0];
        RA_BASE: base_n = reg_wdata[31:32-SLOTSEL_W];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      size_q   <= '0;
      base_q   <= '0;
    end else begin
      strobe_q <= strobe_n;
      size_q   <= size_n;
      base_q   <= base_n;
    end
  end

  assign size_code  = size_q;
  assign base_hi    = base_q;
  assign attach_we  = reg_wr && (reg_addr == RA_ATTACH);
  assign attach_idx = reg_wdata[DIR_IDX_W-1:0];
  assign attach_ent = '{present: reg_wdata[8],
                        attr:    reg_wdata[11:9],
                        page:    reg_wdata[31:20]};
  assign unused_wbits = ^reg_wdata[19:12];

endmodule

// File: rtl/apt_dir.sv
module apt_dir
  import apt_pkg::*;
#(
  parameter int unsigned DIR_ENTRIES = 64,
  parameter int unsigned DIR_IDX_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DIR_IDX_W-1:0] wr_idx,
  input  dir_ent_t             wr_ent,
  input  logic [DIR_IDX_W-1:0] rd_idx,
  output dir_ent_t             rd_ent
);

  dir_ent_t slot_q [DIR_ENTRIES];

  for (genvar g = 0; g < DIR_ENTRIES; g++) begin : g_slot
    logic load;
    assign load = wr_en && (wr_idx == DIR_IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot_q[g] <= '0;
      else if (load) slot_q[g] <= wr_ent;
    end
  end

  assign rd_ent = slot_q[rd_idx];

endmodule

// File: rtl/apt_tlb.sv
module apt_tlb
  import apt_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned PTR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [VPN_W-1:0]  look_vpn,
  output logic              hit,
  output logic [VPN_W-1:0]  hit_ppn,
  output logic [ATTR_W-1:0] hit_attr,
  input  logic              fill_we,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [VPN_W-1:0]  fill_ppn,
  input  logic [ATTR_W-1:0] fill_attr
);

  tlb_ent_t           ent_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PTR_W-1:0]   ptr_q, ptr_n;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic take;
    assign take     = fill_we && (ptr_q == PTR_W'(g));
    assign match[g] = ent_q[g].valid && (ent_q[g].vpn == look_vpn);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_q[g] <= '0;
      else if (clear) ent_q[g].valid <= 1'b0;
      else if (take)  ent_q[g] <= '{valid: 1'b1, vpn: fill_vpn,
                                    ppn: fill_ppn, attr: fill_attr};
    end
  end

  always_comb begin
    hit      = |match;
    hit_ppn  = '0;
    hit_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_ppn  = hit_ppn  | ent_q[i].ppn;
        hit_attr = hit_attr | ent_q[i].attr;
      end
    end
  end

  always_comb begin
    ptr_n = ptr_q;
    if (clear)
      ptr_n = '0;
    else if (fill_we)
      ptr_n = (ptr_q == PTR_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

endmodule

// File: rtl/apt_xlate.sv
module apt_xlate
  import apt_pkg::*;
#(
  parameter int unsigned DIR_ENTRIES = 64,
  parameter int unsigned TLB_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        resp_valid,
  output logic        resp_fault,
  output logic [31:0] resp_paddr,
  output logic [2:0]  resp_attr,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);

  localparam int unsigned DIR_IDX_W = $clog2(DIR_ENTRIES);
  localparam int unsigned TLB_PTR_W = $clog2(TLB_ENTRIES);
  localparam int unsigned REL_W     = SLOTSEL_W + 1;

  logic [7:0]           size_code;
  logic [SLOTSEL_W-1:0] base_hi;
  logic                 flush_pulse, attach_we;
  logic [DIR_IDX_W-1:0] attach_idx;
  dir_ent_t             attach_ent, slot;
  logic                 tlb_clear, tlb_hit, fill_we;
  logic [VPN_W-1:0]     hit_ppn;
  logic [ATTR_W-1:0]    hit_attr;

  xl_state_e         state_q, state_n;
  logic [PA_W-1:0]   addr_q, addr_n;
  logic [PA_W-1:0]   walk_q, walk_n;
  logic              drop_q, drop_n;
  logic              fault_q, fault_n;
  logic [PA_W-1:0]   paddr_q, paddr_n;
  logic [ATTR_W-1:0] attr_q, attr_n;

  aper_sz_t         sz;
  logic [REL_W-1:0] rel, nslots;
  logic             in_range;
  logic             unused_rbits;

  apt_cfg_regs #(.DIR_IDX_W(DIR_IDX_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .size_code, .base_hi, .flush_pulse, .attach_we, .attach_idx, .attach_ent
  );

  // Aperture window check: borrow on subtraction lands far above nslots.
  assign sz       = decode_aper(size_code);
  assign rel      = {1'b0, addr_q[31:32-SLOTSEL_W]} - {1'b0, base_hi};
  assign nslots   = sz.ok ? (REL_W'(DIR_ENTRIES) >> sz.shift) : '0;
  assign in_range = rel < nslots;

  apt_dir #(.DIR_ENTRIES(DIR_ENTRIES), .DIR_IDX_W(DIR_IDX_W)) u_dir (
    .clk, .rst_n,
    .wr_en (attach_we), .wr_idx(attach_idx), .wr_ent(attach_ent),
    .rd_idx(rel[DIR_IDX_W-1:0]), .rd_ent(slot)
  );

  assign tlb_clear = flush_pulse | attach_we;
  assign fill_we   = (state_q == ST_WALK) && mem_rvalid && mem_rdata[0]
                     && !drop_q && !tlb_clear;

  apt_tlb #(.ENTRIES(TLB_ENTRIES), .PTR_W(TLB_PTR_W)) u_tlb (
    .clk, .rst_n, .clear(tlb_clear),
    .look_vpn(addr_q[31:12]), .hit(tlb_hit), .hit_ppn, .hit_attr,
    .fill_we, .fill_vpn(addr_q[31:12]), .fill_ppn(mem_rdata[31:12]),
    .fill_attr(attr_q)
  );

  always_comb begin
    state_n = state_q;
    addr_n  = addr_q;
    walk_n  = walk_q;
    drop_n  = drop_q;
    fault_n = fault_q;
    paddr_n = paddr_q;
    attr_n  = attr_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_n  = req_addr;
          drop_n  = 1'b0;
          state_n = ST_CHECK;
        end
      end
      ST_CHECK: begin
        drop_n = drop_q | tlb_clear;
        if (!in_range) begin
          fault_n = 1'b1; paddr_n = '0; attr_n = '0;
          state_n = ST_RESP;
        end else if (tlb_hit) begin
          fault_n = 1'b0;
          paddr_n = {hit_ppn, addr_q[11:0]};
          attr_n  = hit_attr;
          state_n = ST_RESP;
        end else if (!slot.present) begin
          fault_n = 1'b1; paddr_n = '0; attr_n = '0;
          state_n = ST_RESP;
        end else begin
          walk_n  = {slot.page, 8'h00, addr_q[21:12], 2'b00};
          attr_n  = slot.attr;
          state_n = ST_WALK;
        end
      end
      ST_WALK: begin
        drop_n = drop_q | tlb_clear;
        if (mem_rvalid) begin
          if (mem_rdata[0]) begin
            fault_n = 1'b0;
            paddr_n = {mem_rdata[31:12], addr_q[11:0]};
          end else begin
            fault_n = 1'b1; paddr_n = '0; attr_n = '0;
          end
          state_n = ST_RESP;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      walk_q  <= '0;
      drop_q  <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
      attr_q  <= '0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
      walk_q  <= walk_n;
      drop_q  <= drop_n;
      fault_q <= fault_n;
      paddr_q <= paddr_n;
      attr_q  <= attr_n;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign resp_valid   = (state_q == ST_RESP);
  assign resp_fault   = fault_q;
  assign resp_paddr   = paddr_q;
  assign resp_attr    = attr_q;
  assign mem_rd       = (state_q == ST_WALK);
  assign mem_addr     = walk_q;
  assign unused_rbits = ^{mem_rdata[11:1], rel[REL_W-2:DIR_IDX_W]};

endmodule

// File: rtl/apt_xlate_chk.sv
module apt_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        resp_fault,
  input logic [31:0] resp_paddr,
  input logic [2:0]  resp_attr,
  input logic        mem_rd,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid
);

  // R7: an accepted lookup closes the request channel on the next cycle
  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7: the response strobe lasts one cycle
  a_r7_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R7: no table read while the request channel is open
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd);

  // R5: a pending read keeps its request and address
  a_r5_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

  // R6: a fault carries no address and no attribute
  a_r6_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_paddr == 32'h0 && resp_attr == 3'h0));

endmodule

bind apt_xlate apt_xlate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_fault (resp_fault),
  .resp_paddr (resp_paddr),
  .resp_attr  (resp_attr),
  .mem_rd     (mem_rd),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid)
);

// File: tb/apt_xlate_tb.sv
`timescale 1ns/1ps
module apt_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        resp_valid, resp_fault;
  logic [31:0] resp_paddr;
  logic [2:0]  resp_attr;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, fails = 0, reads = 0, mem_delay = 2, last_cyc = 0;
  logic [31:0] last_waddr = '0;
  bit done = 0;

  bit          dpres [64];
  logic [11:0] dpage [64];
  logic [2:0]  dattr [64];
  logic [31:0] base = '0;
  int          nslots = 64;

  localparam logic [31:0] APB = 32'h4000_0000;

  always #5 clk = ~clk;

  apt_xlate u_dut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .req_valid, .req_ready, .req_addr,
    .resp_valid, .resp_fault, .resp_paddr, .resp_attr,
    .mem_rd, .mem_addr, .mem_rvalid, .mem_rdata
  );

  function automatic logic [31:0] mem_fn(input logic [31:0] w);
    logic [9:0]  off;
    logic [19:0] ppn;
    off = w[11:2];
    ppn = {w[31:20], off[7:0]} ^ 20'h9C5E3;
    return {ppn, 1'b1, off, (off % 5) != 4};
  endfunction

  // memory responder
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_rvalid = 1'b0; cnt = 0;
      end else if (mem_rvalid) begin
        mem_rvalid = 1'b0;
      end else if (mem_rd) begin
        cnt++;
        if (cnt >= mem_delay) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_fn(mem_addr);
          last_waddr = mem_addr;
          reads++;
          cnt = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic attach(input int i, input bit p, input logic [11:0] pg, input logic [2:0] at);
    dpres[i] = p; dpage[i] = pg; dattr[i] = at;
    // reserved bits 19:12 and 7:6 written as ones (R2)
    reg_write(2'd3, {pg, 8'hFF, at, p, 2'b11, 6'(i)});
  endtask

  task automatic set_size(input logic [7:0] code);
    case (code)
      8'd0: nslots = 64; 8'd32: nslots = 32; 8'd48: nslots = 16;
      8'd56: nslots = 8; default: nslots = 0;
    endcase
    reg_write(2'd1, {24'h0, code});
  endtask

  task automatic flush();
    reg_write(2'd0, 32'h2200);
    reg_write(2'd0, 32'h2280);
  endtask

  task automatic lookup(input logic [31:0] a, output bit f, output logic [31:0] pa,
                        output logic [2:0] at, output int nrd);
    int r0, cyc;
    while (!req_ready) @(negedge clk);
    r0 = reads;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!resp_valid && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    last_cyc = cyc;
    f = resp_fault; pa = resp_paddr; at = resp_attr;
    nrd = reads - r0;
  endtask

  task automatic check_xl(input logic [31:0] a, input int exp_rd, input string tagin);
    bit ef, walk, f;
    logic [31:0] epa, waddr, pa;
    logic [2:0] eat, at;
    int rel, nrd;
    logic [9:0] off;
    string tag;
    off = a[21:12];
    rel = int'(a[31:22]) - int'(base[31:22]);
    ef = 1; epa = '0; eat = '0; walk = 0; waddr = '0;
    tag = tagin;
    if (rel < 0 || rel >= nslots) begin
      if (tag == "") tag = "R3";
    end else if (!dpres[rel]) begin
      if (tag == "") tag = "R4";
    end else begin
      if (tag == "") tag = "R6";
      walk = 1;
      waddr = {dpage[rel], 8'h00, off, 2'b00};
      if ((off % 5) != 4) begin
        ef = 0;
        epa = {{dpage[rel], off[7:0]} ^ 20'h9C5E3, a[11:0]};
        eat = dattr[rel];
      end
    end
    if (exp_rd < 0) exp_rd = walk ? 1 : 0;
    lookup(a, f, pa, at, nrd);
    chk({f, pa, at} == {ef, epa, eat}, tag,
        $sformatf("f=%0d pa=%h at=%0d @%h", f, pa, at, a),
        $sformatf("f=%0d pa=%h at=%0d", ef, epa, eat));
    chk(nrd == exp_rd, {tag, " reads"}, $sformatf("%0d @%h", nrd, a), $sformatf("%0d", exp_rd));
    if (walk && nrd > 0)
      chk(last_waddr == waddr, "R5 walk addr", $sformatf("%h", last_waddr), $sformatf("%h", waddr));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] p [5];
    logic [7:0] codes [5] = '{8'd0, 8'd32, 8'd48, 8'd56, 8'd17};
    for (int i = 0; i < 64; i++) begin dpres[i] = 0; dpage[i] = '0; dattr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready && !resp_valid && !mem_rd, "R1 reset outputs",
        $sformatf("%b%b%b", req_ready, resp_valid, mem_rd), "100");
    check_xl(32'h0000_1234, 0, "R1");

    reg_write(2'd2, APB | 32'h0015_ABCD);
    base = APB;
    for (int i = 0; i < 64; i++)
      attach(i, (i % 3) != 2, 12'(12'h800 + i * 7), 3'(i % 8));

    // R2 R3 R4 R5 R6 sweep over every slot and every size case
    for (int s = 0; s < 5; s++) begin
      set_size(codes[s]);
      flush();
      check_xl(APB - 32'h0040_0000 + 32'h1000, -1, "");
      for (int d = 0; d < 66; d++) begin
        check_xl(APB + (32'(d) << 22) + (32'((d * 37 + 1) % 1024) << 12) + 32'(d * 13), -1, "");
        check_xl(APB + (32'(d) << 22) + (32'((d * 11 + 4) % 1024) << 12) + 32'hFFC, -1, "");
      end
    end

    // R8 round-robin replacement
    set_size(8'd0);
    flush();
    p[0] = APB + (32'd0 << 22) + 32'h1010;
    p[1] = APB + (32'd1 << 22) + 32'h1020;
    p[2] = APB + (32'd3 << 22) + 32'h1030;
    p[3] = APB + (32'd4 << 22) + 32'h1040;
    p[4] = APB + (32'd6 << 22) + 32'h1050;
    for (int k = 0; k < 4; k++) check_xl(p[k], 1, "R8 fill");
    for (int k = 0; k < 4; k++) check_xl(p[k], 0, "R8 hit");
    check_xl(p[4], 1, "R8 evict");
    check_xl(p[1], 0, "R8 keep");
    check_xl(p[0], 1, "R8 evicted");
    check_xl(p[1], 1, "R8 next victim");

    // R9 flush strobe semantics
    flush();
    check_xl(p[0], 1, "R9");
    check_xl(p[0], 0, "R9");
    reg_write(2'd0, 32'h2280);
    check_xl(p[0], 0, "R9 no edge");
    reg_write(2'd0, 32'h2200);
    check_xl(p[0], 0, "R9 low");
    reg_write(2'd0, 32'h2280);
    check_xl(p[0], 1, "R9 edge");

    // R7 latency of no-walk lookups
    check_xl(p[0], 0, "R7 hit");
    chk(last_cyc == 1, "R7 hit latency", $sformatf("%0d", last_cyc), "1");
    check_xl(APB + (32'd70 << 22), 0, "R7 range");
    chk(last_cyc == 1, "R7 fault latency", $sformatf("%0d", last_cyc), "1");

    // R10 attach clears cache; R2 present clear
    attach(63, dpres[63], dpage[63], dattr[63]);
    check_xl(p[0], 1, "R10");
    attach(0, 0, 12'h800, 3'd0);
    check_xl(p[0], 0, "R2 absent");
    attach(0, 1, 12'h800, 3'd0);

    // R11 faults not cached; clear during walk blocks fill
    check_xl(APB + 32'h0000_4000, 1, "R11 fault");
    check_xl(APB + 32'h0000_4000, 1, "R11 fault again");
    flush();
    mem_delay = 8;
    fork
      check_xl(p[3], 1, "R11 walk");
      begin
        repeat (3) @(negedge clk);
        reg_write(2'd0, 32'h2200);
        reg_write(2'd0, 32'h2280);
      end
    join
    mem_delay = 2;
    check_xl(p[3], 1, "R11 dropped fill");
    check_xl(p[3], 0, "R11 later fill");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule